// File: doc/BRIEF.md
# ChaCha20 Keystream Block Core

This core turns a 256-bit key, a 32-bit block counter and a 96-bit nonce into one 512-bit ChaCha20 keystream block. The sixteen-word working state is kept in registers, and one time-shared quarter-round datapath runs all 80 quarter-round steps of the 20 rounds. The quarter round is split into two halves. Four pipeline registers sit between the halves. While the second half of one quarter round writes its words back, the first half of the next quarter round is computed in the same cycle. This also holds across round boundaries: the last cycle of a round is the first cycle of the next one.

When the last round is complete, the working state is added to the saved input state, a few words per cycle, using modulo-2^32 adders. Each adder is a sparse prefix adder: it resolves carries per 4-bit group and then selects each group's sum. A caller pulses the start input with the operands applied. It then waits for the one-cycle done pulse and reads the 16 result words, which stay in place until the next accepted start.

Top module: `chacha_keystream_core`

## Requirements
- R1: After reset, busy_o and done_o are low and block_o is all zero.
- R2: The input state is built as: word 0..3 = 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574; word 4+k = key_i[32k+31:32k] for k = 0..7; word 12 = counter_i; word 13+k = nonce_i[32k+31:32k] for k = 0..2. The counter is never carried into the nonce words.
- R3: block_o word w (bits 32w+31:32w) equals the ChaCha20 block function output. That output is 20 rounds, alternating column and diagonal rounds and starting with a column round, each round being four quarter rounds (add, xor, rotate by 16, 12, 8, 7), followed by the final addition.
- R4: Every addition, including the final addition of the input state, is modulo 2^32, and the carry out of bit 31 is dropped.
- R5: A start_i sampled while busy_o is low makes busy_o high on the next cycle. done_o is high for exactly one cycle, and busy_o is low in that cycle.
- R6: A start_i sampled while busy_o is high is ignored: the running block completes with its original operands and its original timing.
- R7: While busy_o is low and start_i is low, block_o does not change, whatever the operand inputs do.
- R8: done_o rises exactly 85 clock edges after the edge that accepts start (80 quarter-round cycles, one drain cycle and four final-add cycles at the default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new block; operands sampled on the same edge |
| key_i | input | 256 | Key, word k in bits 32k+31:32k |
| counter_i | input | 32 | Block counter word |
| nonce_i | input | 96 | Nonce, word k in bits 32k+31:32k |
| busy_o | output | 1 | High while a block is being computed |
| done_o | output | 1 | One-cycle pulse when block_o holds a new result |
| block_o | output | 512 | Result, word w in bits 32w+31:32w |

## Verification
Two things can fall in the same cycle. The first-half write of a quarter round can coincide with the second-half result of the previous quarter round, and at every round boundary the two share a state word that must be forwarded. A start request can also arrive while a block is still running. Both are provoked by every block against a published test vector and by randomly seeded operands, all compared word by word with a behavioural ChaCha20 model in the bench. A start carrying different operands is injected mid-run, and the run is judged by an unchanged result and an unchanged 85-cycle latency.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
    typedef logic [31:0] word_t;

    localparam int NWORDS = 16;

    localparam word_t SIGMA0 = 32'h61707865;
    localparam word_t SIGMA1 = 32'h3320646e;
    localparam word_t SIGMA2 = 32'h79622d32;
    localparam word_t SIGMA3 = 32'h6b206574;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FINAL = 2'd2
    } phase_e;

    // sel[2] is the round parity (1 = diagonal), sel[1:0] the lane.
    // role 0..3 selects a, b, c, d of the quarter round.
    function automatic logic [3:0] qr_word(input logic [2:0] sel, input logic [1:0] role);
        logic [1:0] lane;
        lane = sel[2] ? (sel[1:0] + role) : sel[1:0];
        return {role, lane};
    endfunction
endpackage

// File: rtl/chacha_sparse_add.sv
module chacha_sparse_add #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o
);
    localparam int NG = WIDTH / GROUP;
    localparam int LV = (NG > 1) ? $clog2(NG) : 0;

    logic [LV:0][NG-1:0] gen_q;
    logic [LV:0][NG-1:0] prp_q;
    logic [NG-1:0]       cin;
    logic                gg;
    logic                pp;
    logic [GROUP-1:0]    s0;
    logic [GROUP-1:0]    s1;

    always_comb begin
        // group generate / propagate, rippled inside each 4-bit group
        for (int g = 0; g < NG; g++) begin
            gg = 1'b0;
            pp = 1'b1;
            for (int k = 0; k < GROUP; k++) begin
                gg = (a_i[g*GROUP+k] & b_i[g*GROUP+k]) | ((a_i[g*GROUP+k] ^ b_i[g*GROUP+k]) & gg);
                pp = pp & (a_i[g*GROUP+k] ^ b_i[g*GROUP+k]);
            end
            gen_q[0][g] = gg;
            prp_q[0][g] = pp;
        end
        // prefix tree over group signals
        for (int l = 1; l <= LV; l++) begin
            for (int g = 0; g < NG; g++) begin
                if (g >= (1 << (l-1))) begin
                    gen_q[l][g] = gen_q[l-1][g] | (prp_q[l-1][g] & gen_q[l-1][g-(1<<(l-1))]);
                    prp_q[l][g] = prp_q[l-1][g] & prp_q[l-1][g-(1<<(l-1))];
                end else begin
                    gen_q[l][g] = gen_q[l-1][g];
                    prp_q[l][g] = prp_q[l-1][g];
                end
            end
        end
        cin[0] = 1'b0;
        for (int g = 1; g < NG; g++) begin
            cin[g] = gen_q[LV][g-1];
        end
        // per-group carry select; the carry out of the top bit is dropped
        for (int g = 0; g < NG; g++) begin
            s0 = a_i[g*GROUP +: GROUP] + b_i[g*GROUP +: GROUP];
            s1 = s0 + GROUP'(1);
            sum_o[g*GROUP +: GROUP] = cin[g] ? s1 : s0;
        end
    end
endmodule

// File: rtl/chacha_half_qr.sv
module chacha_half_qr #(
    parameter int ROT_D = 16,
    parameter int ROT_B = 12
) (
    input  logic [3:0][31:0] in_w,
    output logic [3:0][31:0] out_w
);
    logic [31:0] a1, c1, dx, bx, d1, b1;

    chacha_sparse_add #(.WIDTH(32), .GROUP(4)) u_add_ab (
        .a_i   (in_w[0]),
        .b_i   (in_w[1]),
        .sum_o (a1)
    );

    assign dx = in_w[3] ^ a1;
    assign d1 = {dx[31-ROT_D:0], dx[31:32-ROT_D]};

    chacha_sparse_add #(.WIDTH(32), .GROUP(4)) u_add_cd (
        .a_i   (in_w[2]),
        .b_i   (d1),
        .sum_o (c1)
    );

    assign bx = in_w[1] ^ c1;
    assign b1 = {bx[31-ROT_B:0], bx[31:32-ROT_B]};

    assign out_w = {d1, c1, b1, a1};
endmodule

// File: rtl/chacha_keystream_core.sv
module chacha_keystream_core
    import chacha_pkg::*;
#(
    parameter int ROUNDS      = 20,
    parameter int GROUP_WORDS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [255:0] key_i,
    input  logic [31:0]  counter_i,
    input  logic [95:0]  nonce_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [511:0] block_o
);
    localparam int NQR   = ROUNDS * 4;
    localparam int CNT_W = $clog2(NQR + 1);
    localparam int NGRP  = NWORDS / GROUP_WORDS;
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [GRP_W-1:0]  grp;
        logic              pipe_v;
        logic [2:0]        pipe_sel;
        logic [3:0][31:0]  pipe;
        logic [15:0][31:0] st;
        logic [15:0][31:0] init;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;

    logic [3:0][31:0]             hb_out;
    logic [3:0][31:0]             ha_in;
    logic [3:0][31:0]             ha_out;
    logic [15:0][31:0]            fwd;
    logic [GROUP_WORDS-1:0][31:0] fa_a;
    logic [GROUP_WORDS-1:0][31:0] fa_b;
    logic [GROUP_WORDS-1:0][31:0] fa_sum;

    // second half: d<<<8, b<<<7, fed from the pipeline registers
    chacha_half_qr #(.ROT_D(8), .ROT_B(7)) u_half_b (
        .in_w  (r_q.pipe),
        .out_w (hb_out)
    );

    // forward second-half results so the next first half sees them
    always_comb begin
        fwd = r_q.st;
        if (r_q.pipe_v) begin
            for (int role = 0; role < 4; role++) begin
                fwd[qr_word(r_q.pipe_sel, 2'(role))] = hb_out[role];
            end
        end
        for (int role = 0; role < 4; role++) begin
            ha_in[role] = fwd[qr_word(r_q.cnt[2:0], 2'(role))];
        end
    end

    // first half: d<<<16, b<<<12
    chacha_half_qr #(.ROT_D(16), .ROT_B(12)) u_half_a (
        .in_w  (ha_in),
        .out_w (ha_out)
    );

    // final addition, GROUP_WORDS words per cycle
    always_comb begin
        for (int i = 0; i < GROUP_WORDS; i++) begin
            fa_a[i] = r_q.st[4'(int'(r_q.grp) * GROUP_WORDS + i)];
            fa_b[i] = r_q.init[4'(int'(r_q.grp) * GROUP_WORDS + i)];
        end
    end

    for (genvar gi = 0; gi < GROUP_WORDS; gi++) begin : g_final_add
        chacha_sparse_add #(.WIDTH(32), .GROUP(4)) u_fadd (
            .a_i   (fa_a[gi]),
            .b_i   (fa_b[gi]),
            .sum_o (fa_sum[gi])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.init[0] = SIGMA0;
                    r_d.init[1] = SIGMA1;
                    r_d.init[2] = SIGMA2;
                    r_d.init[3] = SIGMA3;
                    for (int k = 0; k < 8; k++) begin
                        r_d.init[4+k] = key_i[32*k +: 32];
                    end
                    r_d.init[12] = counter_i;
                    for (int k = 0; k < 3; k++) begin
                        r_d.init[13+k] = nonce_i[32*k +: 32];
                    end
                    r_d.st     = r_d.init;
                    r_d.phase  = PH_RUN;
                    r_d.cnt    = '0;
                    r_d.pipe_v = 1'b0;
                end
            end
            PH_RUN: begin
                r_d.st = fwd;
                if (int'(r_q.cnt) < NQR) begin
                    r_d.pipe     = ha_out;
                    r_d.pipe_v   = 1'b1;
                    r_d.pipe_sel = r_q.cnt[2:0];
                    r_d.cnt      = r_q.cnt + CNT_W'(1);
                end else begin
                    r_d.pipe_v = 1'b0;
                    r_d.phase  = PH_FINAL;
                    r_d.grp    = '0;
                end
            end
            PH_FINAL: begin
                for (int i = 0; i < GROUP_WORDS; i++) begin
                    r_d.st[4'(int'(r_q.grp) * GROUP_WORDS + i)] = fa_sum[i];
                end
                if (int'(r_q.grp) == NGRP - 1) begin
                    r_d.phase = PH_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.grp = r_q.grp + GRP_W'(1);
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.phase != PH_IDLE);
    assign done_o  = r_q.done;
    assign block_o = r_q.st;
endmodule

// File: rtl/chacha_core_checker.sv
module chacha_core_checker #(
    parameter int ROUNDS      = 20,
    parameter int GROUP_WORDS = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [511:0] block_o
);
    localparam int LAT   = ROUNDS * 4 + 1 + 16 / GROUP_WORDS;
    localparam int LAT_W = $clog2(LAT + 2);

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + LAT_W'(1);
        end
    end

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && (int'(lat_q) < LAT - 1) |=> busy_o);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable(block_o));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(lat_q) == LAT));
endmodule

bind chacha_keystream_core chacha_core_checker #(
    .ROUNDS      (ROUNDS),
    .GROUP_WORDS (GROUP_WORDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .block_o (block_o)
);

// File: tb/chacha_keystream_core_test.sv
module chacha_keystream_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [255:0] key_i = '0;
    logic [31:0]  counter_i = '0;
    logic [95:0]  nonce_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [511:0] block_o;

    int checks = 0;
    int failures = 0;
    localparam int EXP_LAT = 85;

    always #10 clk = ~clk;

    chacha_keystream_core uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .counter_i(counter_i), .nonce_i(nonce_i), .busy_o(busy_o),
        .done_o(done_o), .block_o(block_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [511:0] model(input logic [255:0] k, input logic [31:0] c, input logic [95:0] n);
        logic [31:0] s [16];
        logic [31:0] x [16];
        int qa [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
        int qb [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
        int qc [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
        int qd [8] = '{12, 13, 14, 15, 15, 12, 13, 14};
        logic [511:0] r;
        s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
        for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
        s[12] = c;
        for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
        for (int i = 0; i < 16; i++) x[i] = s[i];
        for (int dr = 0; dr < 10; dr++) begin
            for (int q = 0; q < 8; q++) begin
                x[qa[q]] = x[qa[q]] + x[qb[q]]; x[qd[q]] = rl(x[qd[q]] ^ x[qa[q]], 16);
                x[qc[q]] = x[qc[q]] + x[qd[q]]; x[qb[q]] = rl(x[qb[q]] ^ x[qc[q]], 12);
                x[qa[q]] = x[qa[q]] + x[qb[q]]; x[qd[q]] = rl(x[qd[q]] ^ x[qa[q]], 8);
                x[qc[q]] = x[qc[q]] + x[qd[q]]; x[qb[q]] = rl(x[qb[q]] ^ x[qc[q]], 7);
            end
        end
        for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Accept a start, optionally inject a second start mid-run, wait for done.
    task automatic run_block(input logic [255:0] k, input logic [31:0] c, input logic [95:0] n,
                             input bit inject, output logic [511:0] got, output int lat);
        @(negedge clk);
        start_i = 1'b1; key_i = k; counter_i = c; nonce_i = n;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        key_i = ~k; counter_i = ~c; nonce_i = ~n;
        lat = 1;
        while (!done_o && lat < 400) begin
            if (inject && lat == 10) start_i = 1'b1;
            if (inject && lat == 11) start_i = 1'b0;
            @(negedge clk);
            if (!done_o) lat++;
        end
        start_i = 1'b0;
        got = block_o;
    endtask

    task automatic full_check(input logic [255:0] k, input logic [31:0] c, input logic [95:0] n,
                              input string req);
        logic [511:0] got;
        logic [511:0] exp;
        int lat;
        exp = model(k, c, n);
        run_block(k, c, n, 1'b0, got, lat);
        check(got == exp, req, "block", got, exp);
        check(lat == EXP_LAT, "R8", "latency", 512'(lat), 512'(EXP_LAT));
        @(negedge clk);
        check(!done_o && !busy_o, "R5", "done one cycle", {510'd0, done_o, busy_o}, 512'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [255:0] k;
        logic [95:0]  n;
        logic [511:0] got;
        logic [511:0] exp;
        logic [511:0] held;
        int lat;
        void'($urandom(32'h5eed));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && block_o == '0, "R1", "reset state",
              {busy_o, done_o, block_o[509:0]}, 512'd0);

        // R2 R3: published vector, key bytes 00..1f, counter 1
        for (int i = 0; i < 8; i++)
            k[32*i +: 32] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
        n = {32'h00000000, 32'h4a000000, 32'h09000000};
        exp = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
               32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
               32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
               32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};
        run_block(k, 32'd1, n, 1'b0, got, lat);
        check(got == exp, "R3", "published vector", got, exp);
        check(got == model(k, 32'd1, n), "R2", "model agrees", got, model(k, 32'd1, n));
        check(lat == EXP_LAT, "R8", "latency", 512'(lat), 512'(EXP_LAT));

        // R3: all-zero inputs, first word known
        run_block('0, 32'd0, '0, 1'b0, got, lat);
        check(got[31:0] == 32'hade0b876 && got[63:32] == 32'h903df1a0, "R3", "zero key words",
              got, model('0, 32'd0, '0));

        // R4: all-ones operands exercise every carry chain
        full_check({256{1'b1}}, 32'hffffffff, {96{1'b1}}, "R4");
        // R2: counter at its maximum does not carry into the nonce
        full_check(256'h0, 32'hffffffff, 96'h0, "R2");

        // R7: idle output holds while operands wiggle
        held = block_o;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            key_i = {8{$urandom}}; counter_i = $urandom; nonce_i = {3{$urandom}};
        end
        @(negedge clk);
        check(block_o == held, "R7", "idle hold", block_o, held);

        // R6: start while busy with other operands is ignored
        k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        n = {$urandom, $urandom, $urandom};
        run_block(k, 32'h00000007, n, 1'b1, got, lat);
        exp = model(k, 32'h00000007, n);
        check(got == exp, "R6", "start while busy", got, exp);
        check(lat == EXP_LAT, "R6", "latency under extra start", 512'(lat), 512'(EXP_LAT));

        // R3: constrained-random operands
        for (int t = 0; t < 12; t++) begin
            k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            n = {$urandom, $urandom, $urandom};
            full_check(k, $urandom, n, "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule